// File: doc/BRIEF.md
# Data-Link Zero Stuffer and Destuffer

This block applies bit transparency to a serial data-link channel that shares a framed line with payload traffic. It has two independent halves. The transmit half accepts source bits through a ready/valid handshake. After a run of five accepted ones it places an extra zero on its output, so the source data can never look like a flag or an abort. The receive half watches the incoming channel and removes any zero that follows exactly five ones. A zero that ends a run of six or more ones is passed on, so flags and aborts reach the host unchanged.

Both halves move only on cycles where their data-link strobe is high. The strobe marks the line positions that belong to the channel. Each half has its own enable. When a half is disabled it passes every strobed bit straight through after one register. The transmit half lowers its ready for exactly one strobe while it sends an inserted zero, so the source holds its bit and none is lost. The receive half reports a removed bit by keeping its output valid low after that strobe.

Top module: `dl_bitstuff_pair`

## Requirements
- R1: Right after reset, src_ready is 1, tx_vld is 0 and rx_ovld is 0.
- R2: With stuff_en high, once an accepted 1 completes five ones in a row on the output, the next strobe sends a 0 (tx_vld 1, tx_bit 0) that does not come from the source.
- R3: src_ready is 0 from the cycle after the accepting strobe that completes the run until the strobe that sends the inserted zero, and 1 after it. The source bits come out in order, with none lost or repeated.
- R4: With stuff_en low, src_ready stays 1, and every bit accepted on a strobe appears on tx_bit with tx_vld high one cycle later.
- R5: With destuff_en high, a 0 that follows exactly five strobed ones is removed: rx_ovld is 0 in the cycle after that strobe. A strobed 1 is never removed.
- R6: With destuff_en high, a 0 that follows six or more strobed ones is kept: rx_ovld is 1 and rx_obit is 0.
- R7: With destuff_en low, every strobed rx_bit appears on rx_obit with rx_ovld high one cycle later.
- R8: The run counts change only on strobes. Idle cycles between strobes neither break a run nor produce output, and tx_vld and rx_ovld are high only in the cycle after a strobe.
- R9: A transmit strobe that finds src_valid low and no zero pending produces no output (tx_vld 0) and leaves the run count unchanged.
- R10: A stuffed stream fed into the enabled destuffer comes out equal to the original source bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stuff_en | input | 1 | Enables zero insertion on the transmit half |
| tx_stb | input | 1 | Transmit data-link bit position strobe |
| src_valid | input | 1 | Source offers a bit |
| src_bit | input | 1 | Source bit |
| src_ready | output | 1 | Transmit half accepts the source bit on a strobe |
| tx_bit | output | 1 | Transmitted data-link bit |
| tx_vld | output | 1 | tx_bit holds a new bit this cycle |
| destuff_en | input | 1 | Enables zero removal on the receive half |
| rx_stb | input | 1 | Receive data-link bit position strobe |
| rx_bit | input | 1 | Received data-link bit |
| rx_obit | output | 1 | Bit passed to the host |
| rx_ovld | output | 1 | rx_obit holds a kept bit this cycle |

## Verification
The bench sweeps every 10-bit source pattern through the stuffer and back through the destuffer, which covers runs ending at a pattern edge and runs of ten ones that need two insertions. A stuffer that counted the inserted zero as data, or that forgot to stall, would produce a stream longer or shorter than expected, or would drop a source bit. The receive side is driven with runs of zero to eight ones before a zero. A destuffer that tested "five or more" would eat the last zero of a flag, and one that tested "exactly six" would keep stuffed zeros. Idle cycles and invalid strobes are placed inside a run to catch a counter that advances or clears on non-strobe cycles.

// File: rtl/dl_stuff_pkg.sv
package dl_stuff_pkg;
  // Width able to hold a saturating count of 0 .. run_len+1.
  function automatic int run_cnt_width(input int run_len);
    return $clog2(run_len + 2);
  endfunction
endpackage

// File: rtl/dl_run_counter.sv
module dl_run_counter #(
  parameter int MAX_RUN = 6,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          bit_in,
  output logic [CW-1:0] run
);
  localparam logic [CW-1:0] SAT = CW'(MAX_RUN);

  // Counts consecutive ones on advancing cycles; a zero clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (adv) begin
      if (!bit_in)
        run <= '0;
      else if (run != SAT)
        run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/dl_zero_stuffer.sv
module dl_zero_stuffer #(
  parameter int RUN_LEN = 5,
  parameter int CW      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic stb,
  input  logic src_valid,
  input  logic src_bit,
  output logic src_ready,
  output logic out_bit,
  output logic out_vld
);
  localparam logic [CW-1:0] TRIG = CW'(RUN_LEN - 1);

  logic          pend;
  logic [CW-1:0] run;
  logic          take;
  logic          send_ins;
  logic          adv;
  logic          cur;

  assign take     = stb & src_valid & ~pend;
  assign send_ins = stb & pend;
  assign adv      = take | send_ins;
  assign cur      = pend ? 1'b0 : src_bit;

  dl_run_counter #(.MAX_RUN(RUN_LEN + 1), .CW(CW)) run_i (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .bit_in (cur),
    .run    (run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= adv;
      if (adv)
        out_bit <= cur;
      if (send_ins)
        pend <= 1'b0;
      else if (take && en && src_bit && run >= TRIG)
        pend <= 1'b1;
    end
  end

  assign src_ready = ~pend;
endmodule

// File: rtl/dl_zero_destuffer.sv
module dl_zero_destuffer #(
  parameter int RUN_LEN = 5,
  parameter int CW      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic stb,
  input  logic in_bit,
  output logic out_bit,
  output logic out_vld
);
  localparam logic [CW-1:0] EXACT = CW'(RUN_LEN);

  logic [CW-1:0] run;
  logic          drop;

  dl_run_counter #(.MAX_RUN(RUN_LEN + 1), .CW(CW)) run_i (
    .clk    (clk),
    .rst    (rst),
    .adv    (stb),
    .bit_in (in_bit),
    .run    (run)
  );

  // Only a zero after exactly RUN_LEN ones is removed; longer runs keep it.
  assign drop = stb & en & ~in_bit & (run == EXACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= stb & ~drop;
      if (stb)
        out_bit <= in_bit;
    end
  end
endmodule

// File: rtl/dl_bitstuff_pair.sv
module dl_bitstuff_pair #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic stuff_en,
  input  logic tx_stb,
  input  logic src_valid,
  input  logic src_bit,
  output logic src_ready,
  output logic tx_bit,
  output logic tx_vld,
  input  logic destuff_en,
  input  logic rx_stb,
  input  logic rx_bit,
  output logic rx_obit,
  output logic rx_ovld
);
  localparam int CW = dl_stuff_pkg::run_cnt_width(RUN_LEN);

  dl_zero_stuffer #(.RUN_LEN(RUN_LEN), .CW(CW)) stuff_i (
    .clk       (clk),
    .rst       (rst),
    .en        (stuff_en),
    .stb       (tx_stb),
    .src_valid (src_valid),
    .src_bit   (src_bit),
    .src_ready (src_ready),
    .out_bit   (tx_bit),
    .out_vld   (tx_vld)
  );

  dl_zero_destuffer #(.RUN_LEN(RUN_LEN), .CW(CW)) destuff_i (
    .clk     (clk),
    .rst     (rst),
    .en      (destuff_en),
    .stb     (rx_stb),
    .in_bit  (rx_bit),
    .out_bit (rx_obit),
    .out_vld (rx_ovld)
  );
endmodule

// File: rtl/dl_bitstuff_chk.sv
module dl_bitstuff_chk (
  input logic clk,
  input logic rst,
  input logic stuff_en,
  input logic tx_stb,
  input logic src_valid,
  input logic src_ready,
  input logic tx_bit,
  input logic tx_vld,
  input logic destuff_en,
  input logic rx_stb,
  input logic rx_bit,
  input logic rx_obit,
  input logic rx_ovld
);
  a_r2_inserted_is_zero: assert property (@(posedge clk) disable iff (rst)
    (!src_ready && tx_stb) |=> (tx_vld && !tx_bit));

  a_r3_stall_one_strobe: assert property (@(posedge clk) disable iff (rst)
    (!src_ready && tx_stb) |=> src_ready);

  a_r4_ready_held_when_off: assert property (@(posedge clk) disable iff (rst)
    (!stuff_en && src_ready) |=> src_ready);

  a_r5_ones_never_removed: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && rx_bit) |=> (rx_ovld && rx_obit));

  a_r7_rx_bypass: assert property (@(posedge clk) disable iff (rst)
    (!destuff_en && rx_stb) |=> (rx_ovld && rx_obit == $past(rx_bit)));

  a_r8_tx_quiet: assert property (@(posedge clk) disable iff (rst)
    !tx_stb |=> !tx_vld);

  a_r8_rx_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_stb |=> !rx_ovld);

  a_r9_no_source_no_output: assert property (@(posedge clk) disable iff (rst)
    (tx_stb && src_ready && !src_valid) |=> !tx_vld);
endmodule

bind dl_bitstuff_pair dl_bitstuff_chk chk_i (.*);

// File: tb/dl_bitstuff_pair_tb.sv
module dl_bitstuff_pair_tb_top;
  localparam int CLK_P = 10;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stuff_en = 1'b0, tx_stb = 1'b0, src_valid = 1'b0, src_bit = 1'b0;
  logic destuff_en = 1'b0, rx_stb = 1'b0, rx_bit = 1'b0;
  logic src_ready, tx_bit, tx_vld, rx_obit, rx_ovld;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dl_bitstuff_pair #(.RUN_LEN(5)) dut_i (
    .clk(clk), .rst(rst), .stuff_en(stuff_en), .tx_stb(tx_stb),
    .src_valid(src_valid), .src_bit(src_bit), .src_ready(src_ready),
    .tx_bit(tx_bit), .tx_vld(tx_vld), .destuff_en(destuff_en),
    .rx_stb(rx_stb), .rx_bit(rx_bit), .rx_obit(rx_obit), .rx_ovld(rx_ovld)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Every task starts and ends just after a falling edge.
  task automatic do_reset;
    rst = 1'b1;
    tx_stb = 1'b0; src_valid = 1'b0; rx_stb = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tx_step(input logic b, input logic v,
                         output logic acc, output logic ov, output logic ob);
    acc = src_ready & v;
    tx_stb = 1'b1; src_valid = v; src_bit = b;
    @(posedge clk);
    @(negedge clk);
    tx_stb = 1'b0; src_valid = 1'b0;
    ov = tx_vld; ob = tx_bit;
  endtask

  task automatic rx_step(input logic b, output logic ov, output logic ob);
    rx_stb = 1'b1; rx_bit = b;
    @(posedge clk);
    @(negedge clk);
    rx_stb = 1'b0;
    ov = rx_ovld; ob = rx_obit;
  endtask

  initial begin
    logic acc, ov, ob;
    logic [15:0] exp_s, got_s, rec_s;
    int exp_n, got_n, rec_n, ones, idx, guard;

    @(negedge clk);
    do_reset();
    chk(src_ready == 1'b1, "R1", "src_ready after reset", src_ready, 1);
    chk(tx_vld == 1'b0, "R1", "tx_vld after reset", tx_vld, 0);
    chk(rx_ovld == 1'b0, "R1", "rx_ovld after reset", rx_ovld, 0);

    // Sweep of all 10-bit sources, stuffed then destuffed (R2, R3, R10).
    stuff_en = 1'b1; destuff_en = 1'b1;
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      exp_s = '0; exp_n = 0; ones = 0;
      for (int i = 0; i < 10; i++) begin
        exp_s[exp_n] = p[i]; exp_n++;
        ones = p[i] ? ones + 1 : 0;
        if (ones == 5) begin
          exp_s[exp_n] = 1'b0; exp_n++; ones = 0;
        end
      end
      got_s = '0; got_n = 0; idx = 0; guard = 0;
      while (idx < 10 && guard < 40) begin
        tx_step(p[idx], 1'b1, acc, ov, ob);
        if (ov && got_n < 16) begin got_s[got_n] = ob; got_n++; end
        if (acc) idx++;
        guard++;
      end
      tx_step(1'b0, 1'b0, acc, ov, ob);
      if (ov && got_n < 16) begin got_s[got_n] = ob; got_n++; end
      chk(idx == 10, "R3", "source bits accepted", idx, 10);
      chk(got_n == exp_n, "R2", "stuffed length", got_n, exp_n);
      chk(got_s == exp_s, "R2", "stuffed stream", int'(got_s), int'(exp_s));
      chk(src_ready == 1'b1, "R3", "ready after stream", src_ready, 1);
      rec_s = '0; rec_n = 0;
      for (int k = 0; k < got_n; k++) begin
        rx_step(got_s[k], ov, ob);
        if (ov && rec_n < 16) begin rec_s[rec_n] = ob; rec_n++; end
      end
      chk(rec_n == 10 && rec_s[9:0] == p[9:0], "R10", "round trip",
          int'(rec_s), p);
    end

    // Runs of n ones then a zero into the destuffer (R5, R6).
    for (int n = 0; n <= 8; n++) begin
      do_reset();
      rx_step(1'b0, ov, ob);
      for (int k = 0; k < n; k++) rx_step(1'b1, ov, ob);
      rx_step(1'b0, ov, ob);
      if (n == 5)
        chk(ov == 1'b0, "R5", "zero after five ones removed", ov, 0);
      else if (n >= 6)
        chk(ov == 1'b1 && ob == 1'b0, "R6", "zero after long run kept",
            {ov, ob}, 2);
      else
        chk(ov == 1'b1 && ob == 1'b0, "R5", "zero after short run kept",
            {ov, ob}, 2);
      rx_step(1'b1, ov, ob);
      chk(ov == 1'b1 && ob == 1'b1, "R5", "one passes", {ov, ob}, 3);
    end

    // Both halves disabled: plain pass-through (R4, R7).
    stuff_en = 1'b0; destuff_en = 1'b0;
    do_reset();
    for (int p = 0; p < 1024; p += 3) begin
      for (int i = 0; i < 10; i++) begin
        tx_step(p[i], 1'b1, acc, ov, ob);
        chk(acc == 1'b1 && ov == 1'b1 && ob == p[i], "R4", "tx bypass",
            {acc, ov, ob}, {2'b11, p[i]});
        rx_step(p[i], ov, ob);
        chk(ov == 1'b1 && ob == p[i], "R7", "rx bypass", {ov, ob}, {1'b1, p[i]});
      end
    end

    // Idle cycles and invalid strobes inside a transmit run (R8, R9).
    stuff_en = 1'b1;
    do_reset();
    for (int k = 0; k < 3; k++) tx_step(1'b1, 1'b1, acc, ov, ob);
    src_valid = 1'b1; src_bit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    src_valid = 1'b0;
    chk(tx_vld == 1'b0, "R8", "no tx output without strobe", tx_vld, 0);
    tx_step(1'b1, 1'b0, acc, ov, ob);
    chk(ov == 1'b0, "R9", "invalid strobe gives no output", ov, 0);
    tx_step(1'b1, 1'b1, acc, ov, ob);
    tx_step(1'b1, 1'b1, acc, ov, ob);
    chk(src_ready == 1'b0, "R3", "stall after fifth one", src_ready, 0);
    tx_step(1'b1, 1'b1, acc, ov, ob);
    chk(acc == 1'b0 && ov == 1'b1 && ob == 1'b0, "R2", "inserted zero",
        {acc, ov, ob}, 2);
    chk(src_ready == 1'b1, "R3", "ready after insertion", src_ready, 1);

    // Idle cycle inside a receive run (R8).
    destuff_en = 1'b1;
    do_reset();
    for (int k = 0; k < 3; k++) rx_step(1'b1, ov, ob);
    rx_bit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(rx_ovld == 1'b0, "R8", "no rx output without strobe", rx_ovld, 0);
    rx_step(1'b1, ov, ob);
    rx_step(1'b1, ov, ob);
    rx_step(1'b0, ov, ob);
    chk(ov == 1'b0, "R8", "run spans idle cycle", ov, 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule